// File: doc/BRIEF.md
# Chained Channel Read-Ready Combiner

A multi-channel transceiver block gives each channel its own read result: a ready level and a data word. This combiner lets one read port collect that result from a single channel, or from all channels together. It is built as a daisy chain with one element per channel. Each element takes the merged ready and data from the element before it, together with its own channel's ready and data. It passes a new merged pair to the next element, and the last link drives the read response.

An element takes part when the channel-select input names its index, or when broadcast is set. A selected element routes its own ready. In broadcast mode, every element after the first combines its own ready with the upstream ready by AND. An element that is not selected forwards the upstream ready unchanged. Data is merged by OR, and an element that is not selected adds zeros. The head of the chain is tied to "no valid predecessor": ready low and data zero. A select value that names no channel therefore can never produce a response.

The end of the chain is registered. The response ready is a one-cycle pulse when the selected result becomes ready. The response data is captured in the same cycle and held until the next pulse. A change of channel select or broadcast re-arms the pulse, so a channel that is already ready when it is selected is reported at once.

Top module: `chanReadChain`

## Requirements
- R1: With broadcast low and channel select k below NUM_CH, rdReady is high in the cycle after a cycle in which xcvrReady[k] rises. rdData then equals channel k's data word, which is bits [k*DATA_W +: DATA_W] of xcvrData.
- R2: With broadcast high, rdReady pulses in the cycle after all NUM_CH ready bits are high together. rdData then equals the bitwise OR of all channel data words.
- R3: rdReady is high for one cycle per read. While the selected combined ready stays high and the selection does not change, no further pulse occurs. A new pulse needs the combined ready to drop and rise again.
- R4: A change of channel select or broadcast re-arms the pulse. If the newly selected result is already ready, rdReady pulses in the next cycle with the new channel's data. The old channel's ready never produces a pulse after the switch.
- R5: With broadcast low and channel select at NUM_CH or above (chanSel is clog2(NUM_CH)+1 bits wide), rdReady stays low whatever the ready inputs do.
- R6: rdData holds its last captured value in every cycle where rdReady is low, even when the channel data inputs change.
- R7: While rstN is low (synchronous, active low), rdReady and rdData are zero in the cycle after the reset edge.
- R8: Ready changes on channels that are not selected produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chanSel | input | $clog2(NUM_CH)+1 | Channel index for single-channel reads; values at NUM_CH or above select nothing |
| bcast | input | 1 | Broadcast: select every channel |
| xcvrReady | input | NUM_CH | Per-channel ready level |
| xcvrData | input | NUM_CH*DATA_W | Per-channel read data, channel k in bits [k*DATA_W +: DATA_W] |
| rdReady | output | 1 | One-cycle read-complete pulse |
| rdData | output | DATA_W | Read data captured on the pulse and then held |

## Verification
The bench reads one channel right after a switch from another channel that is still ready. A chain that trusted the old result would pulse with stale data, or miss the new channel's first read. Broadcast reads raise the channel readies one at a time. An element that forwarded instead of ANDing would report the read early with partial data. Select values that name no channel expose a head tied to "ready": such a chain would report a read that nobody performed. Holding the combined ready high checks that the response is a single pulse, and changing the data inputs between pulses checks that the captured word is held.

// File: rtl/chanReadPkg.sv
package chanReadPkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadOut;   // capture the chain's merged data into the output register
  } rdStrobe_t;

endpackage

// File: rtl/chanReadElem.sv
// One link of the read chain: merges its own channel's result with the upstream result.
module chanReadElem #(
  parameter int DATA_W   = 16,
  parameter int SEL_W    = 3,
  parameter int IDX      = 0,
  parameter bit IS_FIRST = 1'b0
) (
  input  logic [SEL_W-1:0]  chanSel,
  input  logic              bcast,
  input  logic              upReady,
  input  logic [DATA_W-1:0] upData,
  input  logic              ownReady,
  input  logic [DATA_W-1:0] ownData,
  output logic              dnReady,
  output logic [DATA_W-1:0] dnData
);

  logic hit;
  assign hit = bcast || (chanSel == SEL_W'(IDX));

  generate
    if (IS_FIRST) begin : g_head
      // The head never merges with its predecessor when selected.
      always_comb begin
        dnReady = hit ? ownReady : upReady;
      end
    end else begin : g_body
      always_comb begin
        if (!hit)
          dnReady = upReady;
        else if (bcast)
          dnReady = ownReady & upReady;
        else
          dnReady = ownReady;
      end
    end
  endgenerate

  assign dnData = (hit ? ownData : '0) | upData;

endmodule

// File: rtl/chanReadData.sv
// Datapath: the element chain and the response data register.
module chanReadData
  import chanReadPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic                     bcast,
  input  logic [NUM_CH-1:0]        xcvrReady,
  input  logic [NUM_CH*DATA_W-1:0] xcvrData,
  input  rdStrobe_t                strobe,
  output logic                     chainReady,
  output logic [DATA_W-1:0]        rdData
);

  logic              readyLink [NUM_CH+1];
  logic [DATA_W-1:0] dataLink  [NUM_CH+1];

  // Head of the chain: no valid predecessor.
  assign readyLink[0] = 1'b0;
  assign dataLink[0]  = '0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_link
      chanReadElem #(
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W),
        .IDX     (gi),
        .IS_FIRST(gi == 0)
      ) u_elem (
        .chanSel (chanSel),
        .bcast   (bcast),
        .upReady (readyLink[gi]),
        .upData  (dataLink[gi]),
        .ownReady(xcvrReady[gi]),
        .ownData (xcvrData[gi*DATA_W +: DATA_W]),
        .dnReady (readyLink[gi+1]),
        .dnData  (dataLink[gi+1])
      );
    end
  endgenerate

  assign chainReady = readyLink[NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (strobe.loadOut)
      rdData <= dataLink[NUM_CH];
  end

endmodule

// File: rtl/chanReadCtrl.sv
// Control: turns the chain's ready level into a one-shot response and re-arms on selection change.
module chanReadCtrl
  import chanReadPkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] chanSel,
  input  logic             bcast,
  input  logic             chainReady,
  output rdStrobe_t        strobe,
  output logic             rdReady
);

  localparam int KEY_W = SEL_W + 1;

  logic [KEY_W-1:0] curKey;
  logic [KEY_W-1:0] lastKey;
  logic             prevReady;
  logic             keyChanged;
  logic             fire;

  assign curKey     = {bcast, chanSel};
  assign keyChanged = (curKey != lastKey);
  assign fire       = chainReady && (!prevReady || keyChanged);

  always_comb begin
    strobe         = '0;
    strobe.loadOut = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastKey   <= '0;
      prevReady <= 1'b0;
      rdReady   <= 1'b0;
    end else begin
      lastKey   <= curKey;
      prevReady <= chainReady;
      rdReady   <= fire;
    end
  end

endmodule

// File: rtl/chanReadChain.sv
// Top: chained channel read-ready combiner.
module chanReadChain
  import chanReadPkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int DATA_W = 16,
  localparam int SEL_W  = $clog2(NUM_CH) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SEL_W-1:0]         chanSel,
  input  logic                     bcast,
  input  logic [NUM_CH-1:0]        xcvrReady,
  input  logic [NUM_CH*DATA_W-1:0] xcvrData,
  output logic                     rdReady,
  output logic [DATA_W-1:0]        rdData
);

  rdStrobe_t strobe;
  logic      chainReady;

  chanReadData #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .chanSel   (chanSel),
    .bcast     (bcast),
    .xcvrReady (xcvrReady),
    .xcvrData  (xcvrData),
    .strobe    (strobe),
    .chainReady(chainReady),
    .rdData    (rdData)
  );

  chanReadCtrl #(
    .SEL_W(SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chanSel   (chanSel),
    .bcast     (bcast),
    .chainReady(chainReady),
    .strobe    (strobe),
    .rdReady   (rdReady)
  );

endmodule

// File: rtl/chanReadChecker.sv
// Properties for the read chain, attached to the top by bind.
module chanReadChecker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [SEL_W-1:0]         chanSel,
  input logic                     bcast,
  input logic [NUM_CH-1:0]        xcvrReady,
  input logic [NUM_CH*DATA_W-1:0] xcvrData,
  input logic                     rdReady,
  input logic [DATA_W-1:0]        rdData
);

  logic              selReady;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] orAll;
  logic              noTarget;

  always_comb begin
    selReady = 1'b0;
    selData  = '0;
    orAll    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      orAll = orAll | xcvrData[i*DATA_W +: DATA_W];
      if (chanSel == SEL_W'(i)) begin
        selReady = xcvrReady[i];
        selData  = xcvrData[i*DATA_W +: DATA_W];
      end
    end
  end

  assign noTarget = !bcast && (chanSel >= SEL_W'(NUM_CH));

  // R1: a single-channel response comes from the channel that was selected
  a_r1_single_source: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && !$past(bcast)) |-> ($past(selReady) && rdData == $past(selData)));

  // R2: a broadcast response needs every ready and carries the OR of all data
  a_r2_bcast_all: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && $past(bcast)) |-> (($past(xcvrReady) == {NUM_CH{1'b1}}) && rdData == $past(orAll)));

  // R3: a second consecutive pulse only after a selection change
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> (!rdReady || $past(chanSel) != $past(chanSel, 2) || $past(bcast) != $past(bcast, 2)));

  // R5: a select value naming no channel never yields a response
  a_r5_no_target: assert property (@(posedge clk) disable iff (!rstN)
    noTarget |=> !rdReady);

  // R6: response data only moves together with a pulse
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdReady |-> $stable(rdData));

  // R7: outputs cleared by reset
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rdReady && rdData == '0));

endmodule

bind chanReadChain chanReadChecker #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W),
  .SEL_W (SEL_W)
) u_chanReadChecker (
  .clk      (clk),
  .rstN     (rstN),
  .chanSel  (chanSel),
  .bcast    (bcast),
  .xcvrReady(xcvrReady),
  .xcvrData (xcvrData),
  .rdReady  (rdReady),
  .rdData   (rdData)
);

// File: tb/test_chanReadChain.sv
module test_chanReadChain;

  localparam int NUM_CH = 4;
  localparam int DATA_W = 16;
  localparam int SEL_W  = $clog2(NUM_CH) + 1;
  localparam int NVEC   = 18;

  // Row layout: {bcast, chanSel[2:0], xcvrReady[3:0], expReady, expData[15:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 4'b0000, 1'b0, 16'h0000},  // idle
    {1'b0, 3'd0, 4'b0001, 1'b1, 16'h0011},  // R1 ch0 read
    {1'b0, 3'd0, 4'b0001, 1'b0, 16'h0011},  // R3 held high, no repeat
    {1'b0, 3'd0, 4'b1110, 1'b0, 16'h0011},  // R8 unselected toggles
    {1'b0, 3'd2, 4'b1110, 1'b1, 16'h4400},  // R4 switch to ready ch2
    {1'b0, 3'd2, 4'b1010, 1'b0, 16'h4400},  // ch2 drops
    {1'b0, 3'd2, 4'b1110, 1'b1, 16'h4400},  // R1 ch2 re-read
    {1'b0, 3'd0, 4'b1110, 1'b0, 16'h4400},  // R4 switch to unready ch0, old ready ignored
    {1'b0, 3'd0, 4'b1111, 1'b1, 16'h0011},  // R4 first ch0 read after switch
    {1'b1, 3'd0, 4'b0001, 1'b0, 16'h0011},  // R2 broadcast, partial
    {1'b1, 3'd0, 4'b0011, 1'b0, 16'h0011},  // R2 partial
    {1'b1, 3'd0, 4'b0111, 1'b0, 16'h0011},  // R2 partial
    {1'b1, 3'd0, 4'b1111, 1'b1, 16'hC639},  // R2 all ready
    {1'b1, 3'd0, 4'b1111, 1'b0, 16'hC639},  // R3 no repeat
    {1'b1, 3'd0, 4'b1110, 1'b0, 16'hC639},  // drop
    {1'b0, 3'd5, 4'b1111, 1'b0, 16'hC639},  // R5 no target
    {1'b0, 3'd7, 4'b1111, 1'b0, 16'hC639},  // R5 no target
    {1'b0, 3'd3, 4'b1111, 1'b1, 16'h8008}   // R4 switch to ready ch3
  };

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [SEL_W-1:0]         chanSel = '0;
  logic                     bcast = 1'b0;
  logic [NUM_CH-1:0]        xcvrReady = '0;
  logic [NUM_CH*DATA_W-1:0] xcvrData = {16'h8008, 16'h4400, 16'h0220, 16'h0011};
  logic                     rdReady;
  logic [DATA_W-1:0]        rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  chanReadChain #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_chanReadChain (
    .clk(clk), .rstN(rstN), .chanSel(chanSel), .bcast(bcast),
    .xcvrReady(xcvrReady), .xcvrData(xcvrData),
    .rdReady(rdReady), .rdData(rdData)
  );

  task automatic check(input string req, input logic expReady, input logic [DATA_W-1:0] expData);
    nChecks++;
    if (rdReady !== expReady || rdData !== expData) begin
      nFails++;
      $display("FAIL %s: rdReady=%0b rdData=%h, expected rdReady=%0b rdData=%h",
               req, rdReady, rdData, expReady, expData);
    end
  endtask

  // Inputs are applied at a falling edge; outputs are sampled at the next falling edge.
  task automatic stepCycle();
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    stepCycle();
    check("R7 reset", 1'b0, 16'h0000);
    xcvrReady = '1;
    bcast = 1'b1;
    stepCycle();
    check("R7 reset ignores ready", 1'b0, 16'h0000);
    bcast = 1'b0;
    xcvrReady = '0;
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {bcast, chanSel, xcvrReady} = VEC[i][24:17];
      stepCycle();
      check($sformatf("R1/R2/R3/R4/R5/R8 vector %0d", i), VEC[i][16], VEC[i][15:0]);
    end
    // R6: data inputs change while no read completes
    xcvrReady = '0;
    xcvrData = {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    stepCycle();
    check("R6 hold", 1'b0, 16'h8008);
    stepCycle();
    check("R6 hold again", 1'b0, 16'h8008);
    // R1: new data captured on the next read of ch3
    xcvrData = {16'h1234, 16'h0000, 16'h0000, 16'h0000};
    xcvrReady = 4'b1000;
    stepCycle();
    check("R1 new data ch3", 1'b1, 16'h1234);
    stepCycle();
    check("R3 single pulse", 1'b0, 16'h1234);
    // R7: reset in mid operation
    rstN = 1'b0;
    stepCycle();
    check("R7 mid reset", 1'b0, 16'h0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule